// File: doc/BRIEF.md
# Deep Sleep Entry and Wake Sequencer

This block places a microcontroller core in one of two deep sleep modes and brings it back out. It acts when the instruction decoder reports a halt instruction with a one-cycle strobe. If no wake-up timer interrupt is enabled, the block enters full halt and turns every clock enable off. If a timer interrupt is enabled, the block enters active-halt. In that mode the main oscillator and the clock of one chosen wake-up timer keep running, so a timer can still wake the core. On every entry the block pulses a request that clears the core's interrupt mask, which lets a pending interrupt reach the core.

Wake-up takes one of two paths. A reset event that arrives during sleep starts a counted start-up phase of 256 or 4096 cycles. The core is held during that phase and then restarts from its reset vector. An interrupt wake-up restores the clocks in the next cycle and tells the core to go straight to the waking vector. A one-cycle cause code and a mode output let the rest of the chip follow each transition.

Top module: `deep_sleep_ctrl`

## Requirements
- R1: After reset the mode output is 2'b00 (run). All five clock enables are 1, core_hold is 0, and imask_clr, irq_resume and wake_cause (2'b00 = none) are idle.
- R2: A halt strobe in run mode enters halt (mode 2'b01) from the next cycle if neither timer wake source is enabled. Timer B counts as enabled only when tmr_b_ie and tmr_b_ck_ok are both 1. In halt every clock enable is 0.
- R3: A halt strobe enters active-halt (mode 2'b10) when tmr_a_ie is 1, and timer A is then chosen. It also enters active-halt when tmr_b_ie and tmr_b_ck_ok are both 1, and timer B is then chosen. In active-halt osc_en and only the chosen timer's clock enable are 1, and cpu_clk_en and periph_clk_en are 0.
- R4: imask_clr is 1 for exactly the one cycle after each accepted halt strobe.
- R5: If a wake source valid for the target mode is already pending when the strobe arrives, the block stays in run and the clocks never drop. irq_resume is 1 and wake_cause is 2'b10 in the next cycle. The valid sources are ext_irq, plus the chosen timer's interrupt when the target is active-halt.
- R6: In either sleep mode ext_irq returns the block to run in the next cycle. In active-halt the chosen timer's interrupt does the same. irq_resume is 1 and wake_cause is 2'b10 (interrupt) for that one cycle, with no start-up delay.
- R7: In halt both timer interrupts are ignored. In active-halt the timer that was not chosen is ignored.
- R8: wake_rst_req during sleep enters the start-up phase (mode 2'b11) with wake_cause 2'b01 (reset) for one cycle. The phase lasts 256 cycles when long_delay is 0 and 4096 cycles when it is 1. During it core_hold is 1, osc_en is 1 and cpu_clk_en is 0. The block then returns to run with core_hold 0.
- R9: When wake_rst_req and an interrupt wake arrive in the same cycle, the reset path wins.
- R10: The timer choice is captured when the strobe is accepted. Changes to tmr_a_ie, tmr_b_ie and tmr_b_ck_ok during sleep have no effect.
- R11: The halt strobe is ignored during the start-up phase. wake_rst_req and ext_irq are ignored in run mode when no strobe is present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main oscillator clock |
| rst_n | input | 1 | Active-low reset of the sequencer |
| halt_strobe | input | 1 | One-cycle halt instruction indication from the decoder |
| tmr_a_ie | input | 1 | Interrupt enable of wake-up timer A |
| tmr_b_ie | input | 1 | Overflow interrupt enable of wake-up timer B |
| tmr_b_ck_ok | input | 1 | Timer B clock selection is usable during sleep |
| ext_irq | input | 1 | External interrupt pending |
| tmr_a_irq | input | 1 | Timer A interrupt pending |
| tmr_b_irq | input | 1 | Timer B interrupt pending |
| wake_rst_req | input | 1 | Reset event during sleep |
| long_delay | input | 1 | Start-up length select: 0 = 256, 1 = 4096 cycles |
| cpu_clk_en | output | 1 | CPU clock enable |
| periph_clk_en | output | 1 | Enable for all other peripheral clocks |
| osc_en | output | 1 | Main oscillator enable |
| tmr_a_clk_en | output | 1 | Timer A clock enable |
| tmr_b_clk_en | output | 1 | Timer B clock enable |
| imask_clr | output | 1 | Pulse that clears the core interrupt mask |
| irq_resume | output | 1 | Pulse telling the core to service the waking vector |
| core_hold | output | 1 | Holds the core during start-up |
| wake_cause | output | 2 | One-cycle cause: 01 reset, 10 interrupt, 00 none |
| mode | output | 2 | 00 run, 01 halt, 10 active-halt, 11 start-up |

## Verification
The mode output and the clock enables come from the state register without any further registering. A wrong state or a wrong latched timer choice therefore shows on the ports in the first cycle after the edge that caused it. A fault in the start-up counter only shows when the phase ends, so the bench measures the length of the phase to the exact cycle for both lengths. The wake pulses are checked in the cycle they appear and again in the cycle after, which confirms that they last one cycle.

// File: rtl/deep_sleep_pkg.sv
package deep_sleep_pkg;
  typedef enum logic [1:0] {
    ST_RUN   = 2'b00,
    ST_HALT  = 2'b01,
    ST_AHALT = 2'b10,
    ST_START = 2'b11
  } dsc_state_e;

  localparam logic [1:0] CAUSE_NONE = 2'b00;
  localparam logic [1:0] CAUSE_RST  = 2'b01;
  localparam logic [1:0] CAUSE_IRQ  = 2'b10;

  function automatic logic is_sleep(input dsc_state_e s);
    return (s == ST_HALT) || (s == ST_AHALT);
  endfunction
endpackage

// File: rtl/dsc_mode_pick.sv
module dsc_mode_pick (
  input  logic tmr_a_ie,
  input  logic tmr_b_ie,
  input  logic tmr_b_ck_ok,
  output logic go_active,
  output logic use_b
);
  function automatic logic pick_b(input logic a_ie, input logic b_ie, input logic ck_ok);
    return !a_ie && b_ie && ck_ok;
  endfunction

  always_comb begin
    use_b     = pick_b(tmr_a_ie, tmr_b_ie, tmr_b_ck_ok);
    go_active = tmr_a_ie || use_b;
  end
endmodule

// File: rtl/dsc_startup_cnt.sv
module dsc_startup_cnt #(
  parameter int SHORT_CYC = 256,
  parameter int LONG_CYC  = 4096
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic long_sel,
  output logic cnt_zero
);
  localparam int CNT_W = $clog2(LONG_CYC);

  function automatic logic [CNT_W-1:0] load_val(input logic lng);
    return lng ? CNT_W'(LONG_CYC - 1) : CNT_W'(SHORT_CYC - 1);
  endfunction

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt_q <= '0;
    else if (load)         cnt_q <= load_val(long_sel);
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign cnt_zero = (cnt_q == '0);
endmodule

// File: rtl/dsc_clk_gate.sv
module dsc_clk_gate
  import deep_sleep_pkg::*;
(
  input  dsc_state_e state,
  input  logic       sel_b,
  output logic       cpu_clk_en,
  output logic       periph_clk_en,
  output logic       osc_en,
  output logic       tmr_a_clk_en,
  output logic       tmr_b_clk_en,
  output logic       core_hold
);
  always_comb begin
    cpu_clk_en    = 1'b0;
    periph_clk_en = 1'b0;
    osc_en        = 1'b0;
    tmr_a_clk_en  = 1'b0;
    tmr_b_clk_en  = 1'b0;
    core_hold     = 1'b0;
    unique case (state)
      ST_RUN: begin
        cpu_clk_en    = 1'b1;
        periph_clk_en = 1'b1;
        osc_en        = 1'b1;
        tmr_a_clk_en  = 1'b1;
        tmr_b_clk_en  = 1'b1;
      end
      ST_HALT: ;
      ST_AHALT: begin
        osc_en       = 1'b1;
        tmr_a_clk_en = !sel_b;
        tmr_b_clk_en = sel_b;
      end
      ST_START: begin
        osc_en    = 1'b1;
        core_hold = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/deep_sleep_ctrl.sv
module deep_sleep_ctrl
  import deep_sleep_pkg::*;
#(
  parameter int SHORT_CYC = 256,
  parameter int LONG_CYC  = 4096
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       halt_strobe,
  input  logic       tmr_a_ie,
  input  logic       tmr_b_ie,
  input  logic       tmr_b_ck_ok,
  input  logic       ext_irq,
  input  logic       tmr_a_irq,
  input  logic       tmr_b_irq,
  input  logic       wake_rst_req,
  input  logic       long_delay,
  output logic       cpu_clk_en,
  output logic       periph_clk_en,
  output logic       osc_en,
  output logic       tmr_a_clk_en,
  output logic       tmr_b_clk_en,
  output logic       imask_clr,
  output logic       irq_resume,
  output logic       core_hold,
  output logic [1:0] wake_cause,
  output logic [1:0] mode
);
  dsc_state_e state_q, state_d;
  logic go_active, use_b, sel_b_q;
  logic accept_halt, pend_at_strobe, rst_wake, irq_wake, cnt_zero;
  logic imask_q, resume_q;
  logic [1:0] cause_q;

  dsc_mode_pick u_pick (
    .tmr_a_ie   (tmr_a_ie),
    .tmr_b_ie   (tmr_b_ie),
    .tmr_b_ck_ok(tmr_b_ck_ok),
    .go_active  (go_active),
    .use_b      (use_b)
  );

  // Wake-source decode, kept as named wires for the checker
  always_comb begin
    accept_halt    = (state_q == ST_RUN) && halt_strobe;
    pend_at_strobe = ext_irq || (go_active && (use_b ? tmr_b_irq : tmr_a_irq));
    rst_wake       = is_sleep(state_q) && wake_rst_req;
    irq_wake       = 1'b0;
    if (state_q == ST_HALT)  irq_wake = ext_irq;
    if (state_q == ST_AHALT) irq_wake = ext_irq || (sel_b_q ? tmr_b_irq : tmr_a_irq);
  end

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_RUN:   if (accept_halt && !pend_at_strobe) state_d = go_active ? ST_AHALT : ST_HALT;
      ST_HALT,
      ST_AHALT: begin
        if (rst_wake)      state_d = ST_START;
        else if (irq_wake) state_d = ST_RUN;
      end
      ST_START: if (cnt_zero) state_d = ST_RUN;
      default:  state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_RUN;
      sel_b_q  <= 1'b0;
      imask_q  <= 1'b0;
      resume_q <= 1'b0;
      cause_q  <= CAUSE_NONE;
    end else begin
      state_q  <= state_d;
      if (accept_halt) sel_b_q <= use_b;
      imask_q  <= accept_halt;
      resume_q <= (accept_halt && pend_at_strobe) || (!rst_wake && irq_wake);
      if (rst_wake)                                                 cause_q <= CAUSE_RST;
      else if ((accept_halt && pend_at_strobe) || irq_wake)         cause_q <= CAUSE_IRQ;
      else                                                          cause_q <= CAUSE_NONE;
    end
  end

  dsc_startup_cnt #(.SHORT_CYC(SHORT_CYC), .LONG_CYC(LONG_CYC)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (rst_wake),
    .long_sel(long_delay),
    .cnt_zero(cnt_zero)
  );

  dsc_clk_gate u_gate (
    .state        (state_q),
    .sel_b        (sel_b_q),
    .cpu_clk_en   (cpu_clk_en),
    .periph_clk_en(periph_clk_en),
    .osc_en       (osc_en),
    .tmr_a_clk_en (tmr_a_clk_en),
    .tmr_b_clk_en (tmr_b_clk_en),
    .core_hold    (core_hold)
  );

  assign imask_clr  = imask_q;
  assign irq_resume = resume_q;
  assign wake_cause = cause_q;
  assign mode       = state_q;
endmodule

// File: rtl/dsc_checker.sv
module dsc_checker (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] mode,
  input logic       cpu_clk_en,
  input logic       periph_clk_en,
  input logic       osc_en,
  input logic       tmr_a_clk_en,
  input logic       tmr_b_clk_en,
  input logic       imask_clr,
  input logic       irq_resume,
  input logic       core_hold,
  input logic [1:0] wake_cause,
  input logic       cnt_zero
);
  AST_HALT_ALL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    mode == 2'b01 |-> !(cpu_clk_en || periph_clk_en || osc_en || tmr_a_clk_en || tmr_b_clk_en)); // R2

  AST_AHALT_ONE_TIMER: assert property (@(posedge clk) disable iff (!rst_n)
    mode == 2'b10 |-> osc_en && !cpu_clk_en && !periph_clk_en
                      && $countones({tmr_a_clk_en, tmr_b_clk_en}) == 1); // R3

  AST_IMASK_ON_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (mode inside {2'b01, 2'b10}) && $past(mode) == 2'b00 |-> imask_clr); // R4

  AST_RESUME_IN_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    irq_resume |-> mode == 2'b00 && cpu_clk_en && wake_cause == 2'b10); // R6

  AST_CAUSE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    wake_cause != 2'b00 |=> wake_cause == 2'b00); // R6

  AST_STARTUP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mode == 2'b11 |-> core_hold && osc_en && !cpu_clk_en); // R8

  AST_STARTUP_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    $past(mode) == 2'b11 && mode == 2'b00 |-> $past(cnt_zero)); // R8

  AST_RST_CAUSE_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    wake_cause == 2'b01 |-> mode == 2'b11); // R9
endmodule

bind deep_sleep_ctrl dsc_checker chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .mode         (mode),
  .cpu_clk_en   (cpu_clk_en),
  .periph_clk_en(periph_clk_en),
  .osc_en       (osc_en),
  .tmr_a_clk_en (tmr_a_clk_en),
  .tmr_b_clk_en (tmr_b_clk_en),
  .imask_clr    (imask_clr),
  .irq_resume   (irq_resume),
  .core_hold    (core_hold),
  .wake_cause   (wake_cause),
  .cnt_zero     (cnt_zero)
);

// File: tb/deep_sleep_ctrl_tb_top.sv
module deep_sleep_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic halt_strobe = 0, tmr_a_ie = 0, tmr_b_ie = 0, tmr_b_ck_ok = 0;
  logic ext_irq = 0, tmr_a_irq = 0, tmr_b_irq = 0, wake_rst_req = 0, long_delay = 0;
  logic cpu_clk_en, periph_clk_en, osc_en, tmr_a_clk_en, tmr_b_clk_en;
  logic imask_clr, irq_resume, core_hold;
  logic [1:0] wake_cause, mode;

  int n_chk = 0, n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  deep_sleep_ctrl dut_i (.*);

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cfg(input logic a, input logic b, input logic ok);
    tmr_a_ie = a; tmr_b_ie = b; tmr_b_ck_ok = ok;
  endtask

  // pulse one input-set for one cycle, then sample after the edge
  task automatic strobe_halt();
    halt_strobe = 1; @(negedge clk); halt_strobe = 0;
  endtask

  function automatic int clks();
    return {cpu_clk_en, periph_clk_en, osc_en, tmr_a_clk_en, tmr_b_clk_en};
  endfunction

  task automatic t_reset();
    chk("R1 mode", mode, 0);
    chk("R1 clocks", clks(), 5'b11111);
    chk("R1 hold/pulses", {core_hold, imask_clr, irq_resume, wake_cause}, 0);
  endtask

  task automatic t_plain_halt();
    cfg(0, 1, 0); strobe_halt();
    chk("R2 mode", mode, 1);
    chk("R2 clocks", clks(), 0);
    chk("R4 imask pulse", imask_clr, 1);
    tmr_a_irq = 1; tmr_b_irq = 1; @(negedge clk); tmr_a_irq = 0; tmr_b_irq = 0;
    chk("R4 imask one cycle", imask_clr, 0);
    chk("R7 halt ignores timers", mode, 1);
    ext_irq = 1; @(negedge clk); ext_irq = 0;
    chk("R6 ext wake mode", mode, 0);
    chk("R6 resume", irq_resume, 1);
    chk("R6 cause", wake_cause, 2);
    @(negedge clk);
    chk("R6 cause one cycle", wake_cause, 0);
    chk("R6 resume one cycle", irq_resume, 0);
  endtask

  task automatic t_ahalt_a();
    cfg(1, 1, 1); strobe_halt();
    chk("R3 mode A", mode, 2);
    chk("R3 clocks A", clks(), 5'b00110);
    cfg(0, 1, 1); tmr_b_irq = 1; @(negedge clk); tmr_b_irq = 0;
    chk("R7 unchosen timer ignored", mode, 2);
    chk("R10 choice latched", clks(), 5'b00110);
    tmr_a_irq = 1; @(negedge clk); tmr_a_irq = 0;
    chk("R6 timer A wake", {mode, irq_resume, wake_cause}, {2'b00, 1'b1, 2'b10});
    @(negedge clk);
  endtask

  task automatic t_ahalt_b();
    cfg(0, 1, 1); strobe_halt();
    chk("R3 mode B", mode, 2);
    chk("R3 clocks B", clks(), 5'b00101);
    tmr_a_irq = 1; @(negedge clk); tmr_a_irq = 0;
    chk("R7 timer A ignored when B chosen", mode, 2);
    tmr_b_irq = 1; @(negedge clk); tmr_b_irq = 0;
    chk("R6 timer B wake", {mode, irq_resume, wake_cause}, {2'b00, 1'b1, 2'b10});
    @(negedge clk);
  endtask

  task automatic t_pending();
    cfg(0, 0, 0); ext_irq = 1; strobe_halt(); ext_irq = 0;
    chk("R5 stays run", mode, 0);
    chk("R5 clocks kept", clks(), 5'b11111);
    chk("R5 resume+cause", {irq_resume, wake_cause}, {1'b1, 2'b10});
    chk("R4 imask on pending", imask_clr, 1);
    @(negedge clk);
    cfg(1, 0, 0); tmr_a_irq = 1; strobe_halt(); tmr_a_irq = 0;
    chk("R5 timer pending stays run", {mode, irq_resume}, {2'b00, 1'b1});
    @(negedge clk);
  endtask

  task automatic t_run_ignore();
    wake_rst_req = 1; ext_irq = 1; @(negedge clk); wake_rst_req = 0; ext_irq = 0;
    chk("R11 run ignores wake inputs", {mode, wake_cause, irq_resume}, 0);
  endtask

  task automatic t_rst_wake(input logic lng, input logic active, input int exp_len);
    int n;
    cfg(active, 0, 0); long_delay = lng; strobe_halt();
    chk("R8 asleep before reset", mode, active ? 2 : 1);
    wake_rst_req = 1; @(negedge clk); wake_rst_req = 0;
    chk("R8 start mode", mode, 3);
    chk("R8 cause reset", wake_cause, 1);
    chk("R8 hold/osc/cpu", {core_hold, osc_en, cpu_clk_en}, 3'b110);
    n = 0;
    while (mode == 2'd3 && n < 5000) begin
      n++;
      halt_strobe = (n == 10);
      @(negedge clk);
    end
    halt_strobe = 0;
    chk("R8 start-up length", n, exp_len);
    chk("R11 strobe ignored in start-up", mode, 0);
    chk("R8 released", {core_hold, cpu_clk_en}, 2'b01);
    long_delay = 0;
  endtask

  task automatic t_priority();
    int n;
    cfg(0, 0, 0); strobe_halt();
    wake_rst_req = 1; ext_irq = 1; @(negedge clk); wake_rst_req = 0; ext_irq = 0;
    chk("R9 reset wins mode", mode, 3);
    chk("R9 reset wins cause", {wake_cause, irq_resume}, {2'b01, 1'b0});
    n = 0;
    while (mode == 2'd3 && n < 5000) begin n++; @(negedge clk); end
    chk("R9 short delay after tie", n, 256);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_plain_halt();
    t_ahalt_a();
    t_ahalt_b();
    t_pending();
    t_run_ignore();
    t_rst_wake(1'b0, 1'b0, 256);
    t_rst_wake(1'b1, 1'b1, 4096);
    t_priority();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule